// File: doc/BRIEF.md
# CAN Controller Interrupt Aggregator

This block collects the event and status indications of a small CAN controller and turns them into two registered interrupt request lines. `irq_fifo` serves the receive FIFO: a new pending message, FIFO full and FIFO overrun. `irq_tec` serves transmit completion on either of two mailboxes, bus error conditions and the wake-up event. Each source has its own enable bit. The error sources pass through a second gate, a master error enable, before they reach `irq_tec`.

The block holds the sticky event flags, which software clears by writing 1 to a flag bit. It follows the three error-state levels and detects a start-of-frame falling edge on the receive pin while the controller sleeps. It also holds six configuration bytes: two bit-timing bytes, two filter-configuration bytes, a filter-mode byte and a diagnostic byte. A write to any of these takes effect only while `init_mode` is high. Access goes through a simple single-cycle register bus. Writes are captured on the clock edge, and reads are combinational from `bus_addr`.

The protocol engine drives the event inputs as single-cycle pulses.

Top module: `can_irq_agg`

## Requirements
- R1: After reset, the flag registers and both enable registers read 0, both interrupt outputs are low, and every configuration byte holds CFG_RST (default 0).
- R2: `irq_fifo` is registered. One cycle after the flags update, it equals the OR of flag-register bits 0 (new message), 1 (FIFO full) and 2 (overrun), each ANDed with the same-numbered bit of the general enable register (address 2).
- R3: A pulse on `evt_tx0_done` sets flag bit 3 and a pulse on `evt_tx1_done` sets flag bit 4, each independently. Their OR, ANDed with general enable bit 3, drives `irq_tec`.
- R4: Error-flag register (address 1) bits 0 (warning), 1 (passive), 2 (bus-off) and 3 (last error code) are each ANDed with the same bit of the error enable register (address 3). The OR of these terms reaches `irq_tec` only when general enable bit 5 is set.
- R5: Error flags 0 to 2 follow `st_warn`, `st_passive` and `st_busoff` one cycle after the level changes. Flag 3 is set by an `evt_last_err` pulse and is sticky.
- R6: While `sleep_mode` is high, a synchronized falling edge on `can_rx` sets flag bit 5 (wake-up), which drives `irq_tec` when general enable bit 4 is set. With `sleep_mode` low, a falling edge sets nothing.
- R7: Writing 1 to a bit of address 0 (bits 0-5) or address 1 (bit 3) clears that flag. Writing 0 leaves the flag unchanged. A set event in the same cycle as a clear leaves the flag set.
- R8: An interrupt output stays high while any enabled flag is set and goes low in the cycle after the last enabled flag clears.
- R9: Writes to addresses 4-9 (timing low/high, filter config 0/1, filter mode, diagnostic) change the byte only while `init_mode` is high. Otherwise the write is ignored.
- R10: Reads of addresses 4-9 return the current byte in any mode. Addresses 10-15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Register address |
| bus_wdata | input | DW (8) | Write data |
| bus_rdata | output | DW (8) | Read data (combinational) |
| evt_msg_pend | input | 1 | Pending message count increased (pulse) |
| evt_fifo_full | input | 1 | Receive FIFO became full (pulse) |
| evt_fifo_ovr | input | 1 | Receive FIFO overrun (pulse) |
| evt_tx0_done | input | 1 | Mailbox 0 emptied (pulse) |
| evt_tx1_done | input | 1 | Mailbox 1 emptied (pulse) |
| evt_last_err | input | 1 | New last-error code recorded (pulse) |
| st_warn | input | 1 | Error warning level |
| st_passive | input | 1 | Error passive level |
| st_busoff | input | 1 | Bus-off level |
| init_mode | input | 1 | Controller in initialization mode |
| sleep_mode | input | 1 | Controller asleep; arms wake detection |
| can_rx | input | 1 | CAN receive pin (asynchronous) |
| irq_fifo | output | 1 | Receive FIFO interrupt |
| irq_tec | output | 1 | Transmit/error/status interrupt |
| cfg_timing | output | 2*DW | Bit-timing bytes {high, low} |
| cfg_filter | output | 2*DW | Filter configuration bytes {1, 0} |
| cfg_fmode | output | DW | Filter mode byte |
| cfg_diag | output | DW | Diagnostic byte |

## Verification
The assertions assume that every event input is a single-cycle pulse and that the error-state inputs change only between clock edges as clean levels. They also assume that `init_mode` and `sleep_mode` are held steady across each bus write. The bench drives all inputs at the falling clock edge, raises each event for exactly one cycle and changes the mode inputs only while the bus is idle. `can_rx` is held for several cycles at each level so that the two-stage synchronizer sees every edge.

// File: rtl/can_irq_agg.sv
module can_irq_agg #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [DW-1:0] CFG_RST = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          evt_msg_pend,
  input  logic          evt_fifo_full,
  input  logic          evt_fifo_ovr,
  input  logic          evt_tx0_done,
  input  logic          evt_tx1_done,
  input  logic          evt_last_err,
  input  logic          st_warn,
  input  logic          st_passive,
  input  logic          st_busoff,
  input  logic          init_mode,
  input  logic          sleep_mode,
  input  logic          can_rx,
  output logic          irq_fifo,
  output logic          irq_tec,
  output logic [2*DW-1:0] cfg_timing,
  output logic [2*DW-1:0] cfg_filter,
  output logic [DW-1:0] cfg_fmode,
  output logic [DW-1:0] cfg_diag
);
  localparam int NG = 6;
  localparam int NE = 4;
  localparam int NCFG = 6;
  localparam int CFG_BASE = 4;

  logic [NG-1:0] gflag, ien, gset, gclr;
  logic [NE-1:0] eflag, eien;
  logic [NCFG-1:0][DW-1:0] cfg_q;
  logic rx_s1, rx_s2, rx_s3, wake_fall;
  logic wr, fifo_req, err_req, tec_req;
  logic [AW-1:0] cfg_off;

  assign wr = bus_sel & bus_wr;
  assign wake_fall = sleep_mode & rx_s3 & ~rx_s2;
  assign gset = {wake_fall, evt_tx1_done, evt_tx0_done, evt_fifo_ovr, evt_fifo_full, evt_msg_pend};
  assign gclr = (wr && bus_addr == AW'(0)) ? bus_wdata[NG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
      rx_s3 <= 1'b1;
    end else begin
      rx_s1 <= can_rx;
      rx_s2 <= rx_s1;
      rx_s3 <= rx_s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gflag <= '0;
      eflag <= '0;
      ien   <= '0;
      eien  <= '0;
    end else begin
      gflag <= (gflag & ~gclr) | gset;
      eflag[2:0] <= {st_busoff, st_passive, st_warn};
      eflag[3] <= (eflag[3] & ~(wr && bus_addr == AW'(1) && bus_wdata[3])) | evt_last_err;
      if (wr && bus_addr == AW'(2)) ien  <= bus_wdata[NG-1:0];
      if (wr && bus_addr == AW'(3)) eien <= bus_wdata[NE-1:0];
    end
  end

  for (genvar i = 0; i < NCFG; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[i] <= CFG_RST;
      else if (wr && init_mode && bus_addr == AW'(CFG_BASE + i))
        cfg_q[i] <= bus_wdata;
    end
  end

  assign fifo_req = |(gflag[2:0] & ien[2:0]);
  assign err_req  = ien[5] & |(eflag & eien);
  assign tec_req  = (ien[3] & (gflag[3] | gflag[4])) | (ien[4] & gflag[5]) | err_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_fifo <= 1'b0;
      irq_tec  <= 1'b0;
    end else begin
      irq_fifo <= fifo_req;
      irq_tec  <= tec_req;
    end
  end

  assign cfg_off = bus_addr - AW'(CFG_BASE);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(0))      bus_rdata = DW'(gflag);
    else if (bus_addr == AW'(1)) bus_rdata = DW'(eflag);
    else if (bus_addr == AW'(2)) bus_rdata = DW'(ien);
    else if (bus_addr == AW'(3)) bus_rdata = DW'(eien);
    else if (cfg_off < AW'(NCFG)) bus_rdata = cfg_q[cfg_off[2:0]];
  end

  assign cfg_timing = {cfg_q[1], cfg_q[0]};
  assign cfg_filter = {cfg_q[3], cfg_q[2]};
  assign cfg_fmode  = cfg_q[4];
  assign cfg_diag   = cfg_q[5];
endmodule

module can_irq_agg_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init_mode,
  input logic          sleep_mode,
  input logic          st_busoff,
  input logic          evt_tx0_done,
  input logic [5:0]    ien,
  input logic [5:0]    gflag,
  input logic [3:0]    eflag,
  input logic [6*DW-1:0] cfg_flat,
  input logic          irq_fifo,
  input logic          irq_tec
);
  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_mode |=> $stable(cfg_flat));
  // R2
  fifo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[2:0] == 3'b000) |=> !irq_fifo);
  // R4
  err_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien[5] && !ien[4] && !ien[3]) |=> !irq_tec);
  // R6
  wake_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_mode |=> !$rose(gflag[5]));
  // R5
  busoff_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_busoff |=> eflag[2]);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx0_done |=> gflag[3]);
endmodule

bind can_irq_agg can_irq_agg_chk #(.DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .init_mode(init_mode), .sleep_mode(sleep_mode),
  .st_busoff(st_busoff), .evt_tx0_done(evt_tx0_done), .ien(ien), .gflag(gflag),
  .eflag(eflag), .cfg_flat({cfg_diag, cfg_fmode, cfg_filter, cfg_timing}),
  .irq_fifo(irq_fifo), .irq_tec(irq_tec)
);

// File: tb/can_irq_agg_test.sv
module can_irq_agg_test;
  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic evt_msg_pend = 0, evt_fifo_full = 0, evt_fifo_ovr = 0;
  logic evt_tx0_done = 0, evt_tx1_done = 0, evt_last_err = 0;
  logic st_warn = 0, st_passive = 0, st_busoff = 0;
  logic init_mode = 0, sleep_mode = 0, can_rx = 1;
  logic irq_fifo, irq_tec;
  logic [15:0] cfg_timing, cfg_filter;
  logic [7:0] cfg_fmode, cfg_diag;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  can_irq_agg uut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 irq_fifo", 16'(irq_fifo), 0);
    check("R1 irq_tec", 16'(irq_tec), 0);
    rd_reg(0, v); check("R1 flags", 16'(v), 0);
    rd_reg(2, v); check("R1 enables", 16'(v), 0);
    check("R1 cfg", cfg_timing, 0);
  endtask

  task automatic t_fifo();
    logic [7:0] v;
    wr_reg(2, 8'h01);
    @(negedge clk); evt_fifo_full = 1;
    @(negedge clk); evt_fifo_full = 0;
    @(negedge clk);
    check("R2 full masked", 16'(irq_fifo), 0);
    evt_msg_pend = 1;
    @(negedge clk); evt_msg_pend = 0;
    @(negedge clk);
    check("R2 msg enabled", 16'(irq_fifo), 1);
    wr_reg(0, 8'h00);
    rd_reg(0, v); check("R7 write zero", 16'(v), 16'h03);
    wr_reg(0, 8'h01);
    check("R8 held while full masked", 16'(irq_fifo), 1);
    @(negedge clk);
    check("R8 drop", 16'(irq_fifo), 0);
    wr_reg(0, 8'h02);
  endtask

  task automatic t_tx();
    logic [7:0] v;
    wr_reg(2, 8'h08);
    evt_tx1_done = 1;
    @(negedge clk); evt_tx1_done = 0;
    rd_reg(0, v); check("R3 tx1 flag only", 16'(v), 16'h10);
    @(negedge clk);
    check("R3 irq_tec", 16'(irq_tec), 1);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 0; bus_wdata = 8'h18; evt_tx0_done = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; evt_tx0_done = 0;
    rd_reg(0, v); check("R7 set wins", 16'(v), 16'h08);
    wr_reg(0, 8'h08);
    wr_reg(2, 8'h00);
  endtask

  task automatic t_err();
    logic [7:0] v;
    wr_reg(3, 8'h01);
    st_warn = 1;
    @(negedge clk);
    rd_reg(1, v); check("R5 warn follows", 16'(v), 16'h01);
    @(negedge clk);
    check("R4 master off", 16'(irq_tec), 0);
    wr_reg(2, 8'h20);
    @(negedge clk);
    check("R4 master on", 16'(irq_tec), 1);
    st_warn = 0;
    @(negedge clk); @(negedge clk);
    check("R8 level drop", 16'(irq_tec), 0);
    evt_last_err = 1;
    @(negedge clk); evt_last_err = 0;
    @(negedge clk); @(negedge clk);
    rd_reg(1, v); check("R5 lec sticky", 16'(v), 16'h08);
    check("R4 lec masked", 16'(irq_tec), 0);
    wr_reg(1, 8'h08);
    rd_reg(1, v); check("R7 lec clear", 16'(v), 0);
    wr_reg(2, 8'h00);
    wr_reg(3, 8'h00);
  endtask

  task automatic t_wake();
    logic [7:0] v;
    wr_reg(2, 8'h10);
    can_rx = 0;
    repeat (4) @(negedge clk);
    rd_reg(0, v); check("R6 not armed", 16'(v), 0);
    can_rx = 1;
    repeat (3) @(negedge clk);
    sleep_mode = 1;
    @(negedge clk);
    can_rx = 0;
    repeat (4) @(negedge clk);
    rd_reg(0, v); check("R6 wake flag", 16'(v), 16'h20);
    check("R6 irq_tec", 16'(irq_tec), 1);
    sleep_mode = 0; can_rx = 1;
    wr_reg(0, 8'h20);
    @(negedge clk);
    check("R8 wake drop", 16'(irq_tec), 0);
    wr_reg(2, 8'h00);
  endtask

  task automatic t_protect();
    logic [7:0] v;
    wr_reg(5, 8'hA5);
    check("R9 blocked", cfg_timing, 0);
    init_mode = 1;
    wr_reg(5, 8'hA5);
    wr_reg(9, 8'h3C);
    init_mode = 0;
    check("R9 timing hi", cfg_timing, 16'hA500);
    check("R9 diag", 16'(cfg_diag), 16'h3C);
    wr_reg(9, 8'h00);
    rd_reg(9, v); check("R10 read outside init", 16'(v), 16'h3C);
    rd_reg(12, v); check("R10 unused addr", 16'(v), 0);
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fifo();
    t_tx();
    t_err();
    t_wake();
    t_protect();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule